// File: doc/BRIEF.md
# Interleaved Three-Level Flying-Capacitor Gate Modulator

This block turns a duty word into gate commands for up to four three-level flying-capacitor half-bridge arms, arranged as two phases (left and right) and two tiers (upper and lower). One free-running counter sets the switching period. Each phase compares two carriers against the latched duty: one for its outer switch and one, half a period later, for its inner switch. The second phase runs a fixed fraction of a period behind the first. Every complementary pair passes through a dead-band stage, so the rising switch waits until its partner has been off for a set number of cycles.

A two-bit mode input chooses how many arms switch. In solo mode only the upper-left arm runs. In parallel mode both upper arms run, interleaved. In series mode the upper-left arm runs together with a lower-left arm that drives the same four signals in swapped positions. In mixed mode all four arms run. The block also reports the commanded switch state of each arm as a two-bit code. Duty and mode are taken only at the wrap of the period counter. Until the first wrap after reset, every gate is held off.

Top module: `fcm_modulator`

## Requirements
- R1: The code of an upper arm is {S3, S4} of its commanded state: 00 means S1 and S2 on, 01 means S2 and S4 on, 10 means S1 and S3 on, 11 means S3 and S4 on. Arm k reports its code on state_o[2k+1:2k].
- R2: Over one full period, the S4 command of an arm is on for exactly min(duty, PERIOD) counter cycles. A duty word above PERIOD is clipped to PERIOD.
- R3: The two switches of a complementary pair are never on together. The pairs are S1 with S4, and S2 with S3. Arm k drives S1..S4 on gate_o[4k..4k+3], with S1 on the lowest bit.
- R4: Let x be the phase position of an arm, which is the counter value less the phase offset, modulo PERIOD. S4 is commanded on when x < duty. S3 is commanded on when (x + PERIOD/2) mod PERIOD < duty.
- R5: When the latched duty is above PERIOD/2, an active arm never reports code 00. When it is below PERIOD/2, an active arm never reports code 11.
- R6: In parallel mode (mode 1), arms 0 and 1 both run, and arm 1 has an offset of PERIOD/4, which is 180° divided by the two phases.
- R7: In series mode (mode 2), arm 2 drives its S1, S2, S3 and S4 from the S4, S3, S2 and S1 of arm 0. Its code is therefore the bitwise inverse of the code of arm 0.
- R8: In mixed mode (mode 3), all four arms run. Arms 1 and 3 carry the quarter-period offset, and arms 2 and 3 mirror arms 0 and 1.
- R9: A switch turns on in a cycle only if its commanded level has been steady for the previous DEAD+1 counter cycles. Otherwise both switches of its pair are off.
- R10: The duty and mode inputs take effect only at the counter wrap, from PERIOD-1 to 0. Changes made in the middle of a period have no effect until that wrap.
- R11: Reset forces all gates and codes to 0 until the first wrap. An arm that is not active in the current mode shows gates 0 and code 00.
- R12: In solo mode (mode 0), only arm 0 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_i | input | DW | Duty in counter cycles, 0..PERIOD, clipped above PERIOD |
| mode_i | input | 2 | 0 solo, 1 parallel, 2 series, 3 mixed |
| gate_o | output | 16 | Gate drives, four per arm, S1 on the lowest bit |
| state_o | output | 8 | Commanded switch-state code, two bits per arm |

## Verification
The state codes depend only on the counter and the latched duty register. They are therefore due in the same cycle as the counter value they belong to. A gate turns on one register stage after its command, plus DEAD cycles of dead band. A new duty or mode first appears in the cycle after the edge at which the counter reads PERIOD-1. The bench advances a requirement-level model on every rising edge and queues the expected gates and codes for that edge. The monitor pops each entry at the following falling edge and compares it there, so every output is checked in the cycle its latency predicts.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    localparam int unsigned NUM_ARMS = 4;
    localparam int unsigned GATE_W   = 4 * NUM_ARMS;
    localparam int unsigned CODE_W   = 2 * NUM_ARMS;

    typedef enum logic [1:0] {
        MODE_SOLO = 2'd0,
        MODE_PAR  = 2'd1,
        MODE_SER  = 2'd2,
        MODE_MIX  = 2'd3
    } fcm_mode_e;

    // Commanded state of one phase leg: {inner-lower, outer-lower}
    typedef struct packed {
        logic s3;
        logic s4;
    } leg_cmd_t;

    // One complementary pair after the dead band
    typedef struct packed {
        logic hi;
        logic lo;
    } pair_drv_t;

    // Gate nibble of one arm, switch 1 on bit 0
    typedef struct packed {
        logic sw4;
        logic sw3;
        logic sw2;
        logic sw1;
    } arm_gates_t;

    function automatic arm_gates_t mirror_gates(input arm_gates_t g);
        arm_gates_t m;
        m.sw1 = g.sw4;
        m.sw2 = g.sw3;
        m.sw3 = g.sw2;
        m.sw4 = g.sw1;
        return m;
    endfunction

    function automatic logic arm_enabled(input fcm_mode_e m, input int unsigned phase,
                                         input bit lower);
        if (lower)
            return (m == MODE_MIX) || ((m == MODE_SER) && (phase == 0));
        else
            return (phase == 0) || (m == MODE_PAR) || (m == MODE_MIX);
    endfunction

endpackage

// File: rtl/fcm_timebase.sv
module fcm_timebase
    import fcm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned DW     = 13,
    parameter int unsigned CW     = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] duty_i,
    input  fcm_mode_e     mode_i,
    output logic [CW-1:0] cnt_o,
    output logic [DW-1:0] duty_o,
    output fcm_mode_e     mode_o,
    output logic          run_o
);

    localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
    localparam logic [DW-1:0] DUTY_MAX = DW'(PERIOD);

    logic [DW-1:0] duty_clip;

    always_comb begin
        duty_clip = (duty_i > DUTY_MAX) ? DUTY_MAX : duty_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            duty_o <= '0;
            mode_o <= MODE_SOLO;
            run_o  <= 1'b0;
        end else if (cnt_o == LAST) begin
            cnt_o  <= '0;
            duty_o <= duty_clip;
            mode_o <= mode_i;
            run_o  <= 1'b1;
        end else begin
            cnt_o  <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/fcm_phase_leg.sv
module fcm_phase_leg
    import fcm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned CW     = 13,
    parameter int unsigned DW     = 13,
    parameter int unsigned OFFSET = 0
) (
    input  logic [CW-1:0] cnt_i,
    input  logic [DW-1:0] duty_i,
    output leg_cmd_t      cmd_o
);

    localparam int unsigned SHIFT = (PERIOD - (OFFSET % PERIOD)) % PERIOD;
    localparam int unsigned HALF  = PERIOD / 2;
    localparam logic [CW:0] P_EXT = (CW+1)'(PERIOD);

    logic [CW:0]   sum_outer;
    logic [CW:0]   sum_inner;
    logic [CW-1:0] pos_outer;
    logic [CW-1:0] pos_inner;

    always_comb begin
        sum_outer = {1'b0, cnt_i} + (CW+1)'(SHIFT);
        pos_outer = (sum_outer >= P_EXT) ? CW'(sum_outer - P_EXT) : CW'(sum_outer);
        sum_inner = {1'b0, pos_outer} + (CW+1)'(HALF);
        pos_inner = (sum_inner >= P_EXT) ? CW'(sum_inner - P_EXT) : CW'(sum_inner);
        cmd_o.s4  = 32'(pos_outer) < 32'(duty_i);
        cmd_o.s3  = 32'(pos_inner) < 32'(duty_i);
    end

endmodule

// File: rtl/fcm_deadband.sv
module fcm_deadband
    import fcm_pkg::*;
#(
    parameter int unsigned DEAD = 150,
    parameter int unsigned DTW  = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      cmd_i,
    output pair_drv_t drv_o
);

    logic           held_q;
    logic [DTW-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            wait_q <= '0;
        end else if (cmd_i != held_q) begin
            held_q <= cmd_i;
            wait_q <= DTW'(DEAD);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    always_comb begin
        drv_o.hi = en_i && held_q  && (wait_q == '0);
        drv_o.lo = en_i && !held_q && (wait_q == '0);
    end

endmodule

// File: rtl/fcm_arm_route.sv
module fcm_arm_route
    import fcm_pkg::*;
#(
    parameter bit          LOWER = 1'b0,
    parameter int unsigned PHASE = 0
) (
    input  fcm_mode_e   mode_i,
    input  logic        run_i,
    input  leg_cmd_t    cmd_i,
    input  pair_drv_t   outer_i,
    input  pair_drv_t   inner_i,
    output logic [3:0]  gates_o,
    output logic [1:0]  code_o
);

    arm_gates_t base;
    arm_gates_t routed;
    logic       live;

    always_comb begin
        base.sw1 = outer_i.lo;
        base.sw4 = outer_i.hi;
        base.sw2 = inner_i.lo;
        base.sw3 = inner_i.hi;
        routed   = LOWER ? mirror_gates(base) : base;
        live     = run_i && arm_enabled(mode_i, PHASE, LOWER);
        gates_o  = live ? routed : '0;
        code_o   = live ? (LOWER ? ~cmd_i : cmd_i) : 2'b00;
    end

endmodule

// File: rtl/fcm_modulator.sv
module fcm_modulator
    import fcm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned DEAD   = 150,
    parameter int unsigned DW     = $clog2(PERIOD + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     duty_i,
    input  logic [1:0]        mode_i,
    output logic [GATE_W-1:0] gate_o,
    output logic [CODE_W-1:0] state_o
);

    localparam int unsigned NPHASE = NUM_ARMS / 2;
    localparam int unsigned CW     = $clog2(PERIOD);
    localparam int unsigned DTW    = (DEAD < 1) ? 1 : $clog2(DEAD + 1);

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] duty_q;
    fcm_mode_e     mode_q;
    logic          run_q;

    leg_cmd_t  leg_cmd   [NPHASE];
    pair_drv_t outer_drv [NPHASE];
    pair_drv_t inner_drv [NPHASE];

    fcm_timebase #(
        .PERIOD (PERIOD),
        .DW     (DW),
        .CW     (CW)
    ) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .duty_i (duty_i),
        .mode_i (fcm_mode_e'(mode_i)),
        .cnt_o  (cnt_q),
        .duty_o (duty_q),
        .mode_o (mode_q),
        .run_o  (run_q)
    );

    for (genvar p = 0; p < NPHASE; p++) begin : g_phase
        fcm_phase_leg #(
            .PERIOD (PERIOD),
            .CW     (CW),
            .DW     (DW),
            .OFFSET (p * PERIOD / (2 * NPHASE))
        ) u_leg (
            .cnt_i  (cnt_q),
            .duty_i (duty_q),
            .cmd_o  (leg_cmd[p])
        );

        fcm_deadband #(
            .DEAD (DEAD),
            .DTW  (DTW)
        ) u_db_outer (
            .clk   (clk),
            .rst   (rst),
            .en_i  (run_q),
            .cmd_i (leg_cmd[p].s4),
            .drv_o (outer_drv[p])
        );

        fcm_deadband #(
            .DEAD (DEAD),
            .DTW  (DTW)
        ) u_db_inner (
            .clk   (clk),
            .rst   (rst),
            .en_i  (run_q),
            .cmd_i (leg_cmd[p].s3),
            .drv_o (inner_drv[p])
        );

        fcm_arm_route #(
            .LOWER (1'b0),
            .PHASE (p)
        ) u_upper (
            .mode_i  (mode_q),
            .run_i   (run_q),
            .cmd_i   (leg_cmd[p]),
            .outer_i (outer_drv[p]),
            .inner_i (inner_drv[p]),
            .gates_o (gate_o[4*p +: 4]),
            .code_o  (state_o[2*p +: 2])
        );

        fcm_arm_route #(
            .LOWER (1'b1),
            .PHASE (p)
        ) u_lower (
            .mode_i  (mode_q),
            .run_i   (run_q),
            .cmd_i   (leg_cmd[p]),
            .outer_i (outer_drv[p]),
            .inner_i (inner_drv[p]),
            .gates_o (gate_o[4*(NPHASE+p) +: 4]),
            .code_o  (state_o[2*(NPHASE+p) +: 2])
        );
    end

endmodule

// File: rtl/fcm_modulator_chk.sv
module fcm_modulator_chk
    import fcm_pkg::*;
#(
    parameter int unsigned PERIOD = 5000,
    parameter int unsigned DW     = 13,
    parameter int unsigned CW     = 13
) (
    input logic              clk,
    input logic              rst,
    input logic [GATE_W-1:0] gate_o,
    input logic [CODE_W-1:0] state_o,
    input logic [DW-1:0]     duty_q,
    input fcm_mode_e         mode_q,
    input logic [CW-1:0]     cnt_q,
    input logic              run_q
);

    localparam int unsigned HALF = PERIOD / 2;

    logic [NUM_ARMS-1:0] clash;

    always_comb begin
        for (int k = 0; k < NUM_ARMS; k++) begin
            clash[k] = (gate_o[4*k] & gate_o[4*k+3]) | (gate_o[4*k+1] & gate_o[4*k+2]);
        end
    end

    assert_no_shoot_through_R3: assert property (@(posedge clk) disable iff (rst)
        clash == '0);

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (gate_o == '0) && (state_o == '0));

    assert_idle_until_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (gate_o == '0));

    assert_no_code00_high_duty_R5: assert property (@(posedge clk) disable iff (rst)
        (run_q && (32'(duty_q) > HALF)) |-> (state_o[1:0] != 2'b00));

    assert_no_code11_low_duty_R5: assert property (@(posedge clk) disable iff (rst)
        (run_q && (32'(duty_q) < HALF)) |-> (state_o[1:0] != 2'b11));

    assert_series_swap_R7: assert property (@(posedge clk) disable iff (rst)
        (run_q && (mode_q == MODE_SER)) |->
        (gate_o[11:8] == {gate_o[0], gate_o[1], gate_o[2], gate_o[3]}));

    assert_latch_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> ($stable(duty_q) && $stable(mode_q)));

    assert_dead_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o[0]) |=> !gate_o[3]);

endmodule

bind fcm_modulator fcm_modulator_chk #(
    .PERIOD (PERIOD),
    .DW     (DW),
    .CW     (CW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .gate_o  (gate_o),
    .state_o (state_o),
    .duty_q  (duty_q),
    .mode_q  (mode_q),
    .cnt_q   (cnt_q),
    .run_q   (run_q)
);

// File: tb/sim_fcm_modulator.sv
module sim_fcm_modulator;

    localparam int CLK_PERIOD = 10;
    localparam int P     = 40;
    localparam int DT    = 3;
    localparam int NP    = 2;
    localparam int HALFP = P / 2;
    localparam int DW    = $clog2(P + 1);

    typedef struct packed {
        logic [15:0] g;
        logic [7:0]  s;
        logic        run;
        logic [1:0]  md;
        logic [15:0] cnt;
        logic [15:0] dq;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] duty = '0;
    logic [1:0]    mode = 2'd0;
    logic [15:0]   gate_o;
    logic [7:0]    state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t sb[$];

    int m_cnt, m_duty, m_mode;
    bit m_run;
    bit [DT:0] hist [NP][2];

    int on_cnt;
    bit full_per;

    fcm_modulator #(.PERIOD(P), .DEAD(DT), .DW(DW)) u0 (
        .clk     (clk),
        .rst     (rst),
        .duty_i  (duty),
        .mode_i  (mode),
        .gate_o  (gate_o),
        .state_o (state_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit cmd_bit(int cnt, int d, int ph, int inner);
        int pos;
        pos = (cnt - ph * P / (2 * NP) + P) % P;
        if (inner != 0) pos = (pos + HALFP) % P;
        return pos < d;
    endfunction

    function automatic string mode_tag(bit run, logic [1:0] md);
        if (!run) return "R11";
        case (md)
            2'd0:    return "R12";
            2'd1:    return "R6";
            2'd2:    return "R7";
            default: return "R8";
        endcase
    endfunction

    // Driver side of the scoreboard: advance the model and queue the expectation
    always @(posedge clk) begin
        exp_t e;
        if (rst) begin
            m_cnt = 0; m_duty = 0; m_mode = 0; m_run = 1'b0;
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < 2; k++) hist[p][k] = '0;
        end else begin
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < 2; k++)
                    hist[p][k] = {hist[p][k][DT-1:0], cmd_bit(m_cnt, m_duty, p, k)};
            if (m_cnt == P - 1) begin
                m_cnt  = 0;
                m_duty = (int'(duty) > P) ? P : int'(duty);
                m_mode = int'(mode);
                m_run  = 1'b1;
            end else begin
                m_cnt++;
            end
        end
        e = '0;
        e.run = m_run;
        e.md  = 2'(m_mode);
        e.cnt = 16'(m_cnt);
        e.dq  = 16'(m_duty);
        for (int a = 0; a < 4; a++) begin
            int  p;
            bit  low, act, hia, loa, hib, lob;
            logic [1:0] code;
            p   = a % 2;
            low = (a >= 2);
            act = m_run && (low ? ((m_mode == 3) || ((m_mode == 2) && (p == 0)))
                                : ((p == 0) || (m_mode == 1) || (m_mode == 3)));
            hia = &hist[p][0]; loa = ~|hist[p][0];
            hib = &hist[p][1]; lob = ~|hist[p][1];
            code = {cmd_bit(m_cnt, m_duty, p, 1), cmd_bit(m_cnt, m_duty, p, 0)};
            if (act) begin
                if (low) begin
                    e.g[4*a +: 4] = {loa, lob, hib, hia};
                    e.s[2*a +: 2] = ~code;
                end else begin
                    e.g[4*a +: 4] = {hia, hib, lob, loa};
                    e.s[2*a +: 2] = code;
                end
            end
        end
        sb.push_back(e);
    end

    // Monitor side: compare away from the active edge
    always @(negedge clk) begin
        exp_t e;
        bit clash;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (gate_o !== e.g) begin
                fails++;
                $display("FAIL R9 %s gates: actual %h expected %h (cnt %0d)",
                         mode_tag(e.run, e.md), gate_o, e.g, e.cnt);
            end
            checks++;
            if (state_o !== e.s) begin
                fails++;
                $display("FAIL R1 R4 R10 codes: actual %h expected %h (cnt %0d)",
                         state_o, e.s, e.cnt);
            end
            clash = 1'b0;
            for (int a = 0; a < 4; a++)
                clash |= (gate_o[4*a] & gate_o[4*a+3]) | (gate_o[4*a+1] & gate_o[4*a+2]);
            checks++;
            if (clash) begin
                fails++;
                $display("FAIL R3 pair overlap: actual %h expected no pair both on", gate_o);
            end
            if (e.run && int'(e.dq) > HALFP) begin
                checks++;
                if (state_o[1:0] == 2'b00) begin
                    fails++;
                    $display("FAIL R5 high duty: actual code 00 expected not 00");
                end
            end
            if (e.run && int'(e.dq) < HALFP) begin
                checks++;
                if (state_o[1:0] == 2'b11) begin
                    fails++;
                    $display("FAIL R5 low duty: actual code 11 expected not 11");
                end
            end
            // R2: on-time of the S4 command over a whole period
            if (e.cnt == 0) begin
                on_cnt   = int'(state_o[0]);
                full_per = e.run;
            end else begin
                on_cnt += int'(state_o[0]);
            end
            if (e.run && full_per && e.cnt == 16'(P - 1)) begin
                checks++;
                if (on_cnt != int'(e.dq)) begin
                    fails++;
                    $display("FAIL R2 on-time: actual %0d expected %0d", on_cnt, e.dq);
                end
            end
        end
    end

    task automatic drive(input int d, input logic [1:0] m, input int cycles);
        @(negedge clk);
        duty = DW'(d);
        mode = m;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(30, 2'd0, 3 * P);     // R12 solo, high duty (R5)
        drive(10, 2'd1, 2 * P);     // R6 parallel, low duty
        drive(25, 2'd2, 2 * P);     // R7 series
        drive(15, 2'd3, 2 * P);     // R8 mixed
        drive(20, 2'd3, 2 * P);     // exact half
        drive(0,  2'd1, 2 * P);     // all off commands
        drive(40, 2'd2, 2 * P);     // full duty
        drive(63, 2'd3, 2 * P);     // R2 clipping
        drive(12, 2'd3, 7);         // R10 mid-period changes
        drive(33, 2'd0, 5);
        drive(8,  2'd2, 2 * P);
        @(negedge clk);
        rst = 1'b1;                 // R11 reset again mid-run
        repeat (2) @(negedge clk);
        rst = 1'b0;
        drive(5, 2'd0, 3 * P);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog: actual still running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule